// File: doc/BRIEF.md
# Stateful Match-Action Stage

This block is one stage of a packet pipeline that keeps state per flow. Each accepted packet brings a lookup key, an update key and an 8-bit header/metadata vector. The stage reads the flow's context from a small direct-mapped table. A context is a state label plus two per-flow registers. The stage then matches the current state together with the header vector against eight programmable ternary entries.

The winning entry supplies an action code, a next state and two register-update instructions. Two small ALUs carry out those instructions over the flow registers and two global registers that all flows share. The updated context is written back under the update key before another packet is accepted. A configuration port programs the ternary entries at any clock edge.

The controller is a three-state machine. IDLE holds `in_ready` high and moves to MATCH when a packet is accepted. MATCH reads the context, runs the match and the ALUs, and registers the result; it always moves to WRITE. WRITE presents the result with `out_valid` high, commits the context and the global registers, and always returns to IDLE.

Top module: `flow_state_stage`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, both global registers are 0, every context slot is empty and every ternary entry is disabled.
- R2: A packet is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 for the next two cycles. `out_valid` is 1 for exactly the second cycle after acceptance.
- R3: The context slot is the low 4 bits of the key. If that slot is empty or holds a different full key, the flow starts with state 0 and both flow registers at 0.
- R4: The match vector is {state[3:0], hdr[7:0]}, with the state in bits 11:8. An entry hits when it is enabled and every bit set in its mask equals the same bit of its value. The lowest-index hitting entry wins.
- R5: On a miss, `out_hit` is 0, `out_action` is 0 (drop), `out_next_state` is the current state, and the registers are reported unchanged. No context is written and the global registers keep their values.
- R6: On a hit, `out_action` and `out_next_state` come from the winning entry. The stored state of the flow becomes that next state.
- R7: An instruction is 22 bits: {op[21:20], dst[19:18], src[17:16], imm[15:0]}. The op codes are 0 = nop, 1 = add (dst = src + imm), 2 = sub (dst = src - imm) and 3 = set (dst = imm), all modulo 2^16. Operand index 0..1 selects a flow register and 2..3 a global register. Slot 0 of an entry sits in bits 21:0 of `cfg_ins` and slot 1 in bits 43:22.
- R8: Both instruction slots read the register values from before the packet. When both slots write the same register, slot 1's value is kept.
- R9: The global registers are shared by all flows. Each packet sees every update made by the packets accepted before it.
- R10: The context is written to the slot selected by the update key and is tagged with the full update key. The lookup uses the lookup key.
- R11: The next packet of the same flow sees the state and registers written by the previous one.
- R12: With `cfg_we` high at a rising edge, entry `cfg_idx` is loaded from the cfg fields. `cfg_en` = 0 disables the entry.
- R13: A flow whose slot has been taken by another key restarts from the default context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Stage can accept a packet |
| in_key | input | 16 | Lookup flow key |
| in_upd_key | input | 16 | Key under which the context is stored |
| in_hdr | input | 8 | Header/metadata match vector |
| cfg_we | input | 1 | Write a ternary entry |
| cfg_idx | input | 3 | Entry index |
| cfg_en | input | 1 | Entry enable |
| cfg_val | input | 12 | Match value {state, hdr} |
| cfg_mask | input | 12 | Match mask, 1 = compare |
| cfg_action | input | 4 | Action code of the entry |
| cfg_next_state | input | 4 | Next state of the entry |
| cfg_ins | input | 44 | Two instructions, slot 0 low |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | An entry matched |
| out_action | output | 4 | Action code, 0 on miss |
| out_next_state | output | 4 | State written back |
| out_fregs | output | 32 | Updated flow registers, register i at bits 16i+15:16i |
| out_gregs | output | 32 | Updated global registers, same layout |

## Verification
Two update functions can land on one register in the same cycle. Both instruction slots of an entry write one register, or one slot writes a register that the other slot reads. Entries are programmed so that both slots set flow register 0, and a second entry reads flow register 0 in one slot while the other slot updates a global register. The results are judged against a model in which both slots read the old values and slot 1 is kept on a collision. Global-register updates from different flows that run back to back are checked the same way for accumulation.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_SET = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MATCH = 2'd1,
        S_WRITE = 2'd2
    } stage_state_e;
endpackage

// File: rtl/fss_alu.sv
module fss_alu
    import fss_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int NUM_OPND = 4,
    parameter int OPND_W   = 2,
    localparam int INS_W   = OP_W + 2 * OPND_W + REG_W
) (
    input  logic [INS_W-1:0]  ins,
    input  logic [REG_W-1:0]  opnds [NUM_OPND],
    output logic              wr_en,
    output logic [OPND_W-1:0] wr_dst,
    output logic [REG_W-1:0]  wr_val
);
    logic [OP_W-1:0]   op;
    logic [OPND_W-1:0] src;
    logic [REG_W-1:0]  imm;
    logic [REG_W-1:0]  src_val;

    assign {op, wr_dst, src, imm} = ins;
    assign src_val = opnds[src];

    always_comb begin
        wr_en  = 1'b1;
        wr_val = '0;
        unique case (alu_op_e'(op))
            OP_NOP: wr_en  = 1'b0;
            OP_ADD: wr_val = src_val + imm;
            OP_SUB: wr_val = src_val - imm;
            OP_SET: wr_val = imm;
        endcase
    end
endmodule

// File: rtl/fss_ctx_table.sv
module fss_ctx_table #(
    parameter int KEY_W     = 16,
    parameter int ST_W      = 4,
    parameter int REG_W     = 16,
    parameter int NUM_FREG  = 2,
    parameter int DEPTH     = 16,
    parameter int DEF_STATE = 0,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] rd_key,
    output logic [ST_W-1:0]  rd_state,
    output logic [REG_W-1:0] rd_regs [NUM_FREG],
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [ST_W-1:0]  wr_state,
    input  logic [REG_W-1:0] wr_regs [NUM_FREG]
);
    logic             vld_q  [DEPTH];
    logic [KEY_W-1:0] key_q  [DEPTH];
    logic [ST_W-1:0]  st_q   [DEPTH];
    logic [REG_W-1:0] regs_q [DEPTH][NUM_FREG];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             rd_found;

    assign rd_idx   = rd_key[IDX_W-1:0];
    assign wr_idx   = wr_key[IDX_W-1:0];
    assign rd_found = vld_q[rd_idx] && (key_q[rd_idx] == rd_key);

    always_comb begin
        rd_state = rd_found ? st_q[rd_idx] : ST_W'(DEF_STATE);
        for (int i = 0; i < NUM_FREG; i++)
            rd_regs[i] = rd_found ? regs_q[rd_idx][i] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                vld_q[s] <= 1'b0;
                key_q[s] <= '0;
                st_q[s]  <= '0;
                for (int i = 0; i < NUM_FREG; i++) regs_q[s][i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            key_q[wr_idx] <= wr_key;
            st_q[wr_idx]  <= wr_state;
            for (int i = 0; i < NUM_FREG; i++) regs_q[wr_idx][i] <= wr_regs[i];
        end
    end

    // R10: a written context is found afterwards under the update key
    assert_writeback_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] && key_q[$past(wr_idx)] == $past(wr_key)
                   && st_q[$past(wr_idx)] == $past(wr_state)));
endmodule

// File: rtl/fss_tcam.sv
module fss_tcam #(
    parameter int VEC_W   = 12,
    parameter int NUM_ENT = 8,
    parameter int ACT_W   = 4,
    parameter int ST_W    = 4,
    parameter int PAY_W   = 44,
    localparam int ENT_IDX_W = $clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ENT_IDX_W-1:0] cfg_idx,
    input  logic                 cfg_en,
    input  logic [VEC_W-1:0]     cfg_val,
    input  logic [VEC_W-1:0]     cfg_mask,
    input  logic [ACT_W-1:0]     cfg_action,
    input  logic [ST_W-1:0]      cfg_next_state,
    input  logic [PAY_W-1:0]     cfg_ins,
    input  logic [VEC_W-1:0]     vec,
    output logic                 hit,
    output logic [ACT_W-1:0]     action,
    output logic [ST_W-1:0]      next_state,
    output logic [PAY_W-1:0]     ins
);
    logic                 en_q   [NUM_ENT];
    logic [VEC_W-1:0]     val_q  [NUM_ENT];
    logic [VEC_W-1:0]     mask_q [NUM_ENT];
    logic [ACT_W-1:0]     act_q  [NUM_ENT];
    logic [ST_W-1:0]      nst_q  [NUM_ENT];
    logic [PAY_W-1:0]     ins_q  [NUM_ENT];
    logic [NUM_ENT-1:0]   hit_vec;
    logic [ENT_IDX_W-1:0] win;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                en_q[e]   <= 1'b0;
                val_q[e]  <= '0;
                mask_q[e] <= '0;
                act_q[e]  <= '0;
                nst_q[e]  <= '0;
                ins_q[e]  <= '0;
            end
        end else if (cfg_we) begin
            en_q[cfg_idx]   <= cfg_en;
            val_q[cfg_idx]  <= cfg_val;
            mask_q[cfg_idx] <= cfg_mask;
            act_q[cfg_idx]  <= cfg_action;
            nst_q[cfg_idx]  <= cfg_next_state;
            ins_q[cfg_idx]  <= cfg_ins;
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign hit_vec[e] = en_q[e] && (((vec ^ val_q[e]) & mask_q[e]) == '0);
    end

    always_comb begin
        win = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--)
            if (hit_vec[e]) win = ENT_IDX_W'(e);
    end

    assign hit        = |hit_vec;
    assign action     = act_q[win];
    assign next_state = nst_q[win];
    assign ins        = ins_q[win];

    // R4: the chosen entry is enabled and agrees with the vector on its masked bits
    assert_winner_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (en_q[win] && ((vec & mask_q[win]) == (val_q[win] & mask_q[win]))));
    // R12: a configuration write sets the enable of the addressed entry
    assert_cfg_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (en_q[$past(cfg_idx)] == $past(cfg_en)));
endmodule

// File: rtl/flow_state_stage.sv
module flow_state_stage
    import fss_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int HDR_W     = 8,
    parameter int ST_W      = 4,
    parameter int REG_W     = 16,
    parameter int NUM_FREG  = 2,
    parameter int NUM_GREG  = 2,
    parameter int CTX_DEPTH = 16,
    parameter int NUM_ENT   = 8,
    parameter int ACT_W     = 4,
    parameter int NUM_SLOT  = 2,
    parameter int DEF_STATE = 0,
    parameter int DROP_ACT  = 0,
    localparam int NUM_OPND  = NUM_FREG + NUM_GREG,
    localparam int OPND_W    = $clog2(NUM_OPND),
    localparam int INS_W     = OP_W + 2 * OPND_W + REG_W,
    localparam int PAY_W     = NUM_SLOT * INS_W,
    localparam int VEC_W     = ST_W + HDR_W,
    localparam int ENT_IDX_W = $clog2(NUM_ENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [KEY_W-1:0]          in_key,
    input  logic [KEY_W-1:0]          in_upd_key,
    input  logic [HDR_W-1:0]          in_hdr,
    input  logic                      cfg_we,
    input  logic [ENT_IDX_W-1:0]      cfg_idx,
    input  logic                      cfg_en,
    input  logic [VEC_W-1:0]          cfg_val,
    input  logic [VEC_W-1:0]          cfg_mask,
    input  logic [ACT_W-1:0]          cfg_action,
    input  logic [ST_W-1:0]           cfg_next_state,
    input  logic [PAY_W-1:0]          cfg_ins,
    output logic                      out_valid,
    output logic                      out_hit,
    output logic [ACT_W-1:0]          out_action,
    output logic [ST_W-1:0]           out_next_state,
    output logic [NUM_FREG*REG_W-1:0] out_fregs,
    output logic [NUM_GREG*REG_W-1:0] out_gregs
);
    stage_state_e state_q, state_d;

    logic [KEY_W-1:0] pkt_key_q, upd_key_q;
    logic [HDR_W-1:0] hdr_q;
    logic             res_hit_q;
    logic [ACT_W-1:0] res_act_q;
    logic [ST_W-1:0]  res_nst_q;
    logic [REG_W-1:0] res_fregs_q [NUM_FREG];
    logic [REG_W-1:0] res_gregs_q [NUM_GREG];
    logic [REG_W-1:0] greg_q      [NUM_GREG];
    logic [NUM_GREG*REG_W-1:0] greg_flat;

    logic [ST_W-1:0]  ctx_rd_state;
    logic [REG_W-1:0] ctx_rd_regs [NUM_FREG];
    logic             tc_hit;
    logic [ACT_W-1:0] tc_act;
    logic [ST_W-1:0]  tc_nst;
    logic [PAY_W-1:0] tc_ins;

    logic [REG_W-1:0]  opnd     [NUM_OPND];
    logic [REG_W-1:0]  new_opnd [NUM_OPND];
    logic              alu_we   [NUM_SLOT];
    logic [OPND_W-1:0] alu_dst  [NUM_SLOT];
    logic [REG_W-1:0]  alu_val  [NUM_SLOT];

    fss_ctx_table #(
        .KEY_W(KEY_W), .ST_W(ST_W), .REG_W(REG_W), .NUM_FREG(NUM_FREG),
        .DEPTH(CTX_DEPTH), .DEF_STATE(DEF_STATE)
    ) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .rd_key(pkt_key_q), .rd_state(ctx_rd_state), .rd_regs(ctx_rd_regs),
        .wr_en(state_q == S_WRITE && res_hit_q), .wr_key(upd_key_q),
        .wr_state(res_nst_q), .wr_regs(res_fregs_q)
    );

    fss_tcam #(
        .VEC_W(VEC_W), .NUM_ENT(NUM_ENT), .ACT_W(ACT_W), .ST_W(ST_W), .PAY_W(PAY_W)
    ) u_tcam (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_val(cfg_val),
        .cfg_mask(cfg_mask), .cfg_action(cfg_action), .cfg_next_state(cfg_next_state),
        .cfg_ins(cfg_ins), .vec({ctx_rd_state, hdr_q}),
        .hit(tc_hit), .action(tc_act), .next_state(tc_nst), .ins(tc_ins)
    );

    always_comb begin
        for (int i = 0; i < NUM_FREG; i++) opnd[i] = ctx_rd_regs[i];
        for (int j = 0; j < NUM_GREG; j++) opnd[NUM_FREG + j] = greg_q[j];
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_alu
        fss_alu #(.REG_W(REG_W), .NUM_OPND(NUM_OPND), .OPND_W(OPND_W)) u_alu (
            .ins(tc_ins[s*INS_W +: INS_W]), .opnds(opnd),
            .wr_en(alu_we[s]), .wr_dst(alu_dst[s]), .wr_val(alu_val[s])
        );
    end

    // Both slots read the old values; the higher slot is applied last.
    always_comb begin
        new_opnd = opnd;
        for (int s = 0; s < NUM_SLOT; s++)
            if (tc_hit && alu_we[s]) new_opnd[alu_dst[s]] = alu_val[s];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid) state_d = S_MATCH;
            S_MATCH: state_d = S_WRITE;
            S_WRITE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready       = (state_q == S_IDLE);
        out_valid      = (state_q == S_WRITE);
        out_hit        = res_hit_q;
        out_action     = res_act_q;
        out_next_state = res_nst_q;
        for (int i = 0; i < NUM_FREG; i++) out_fregs[i*REG_W +: REG_W] = res_fregs_q[i];
        for (int j = 0; j < NUM_GREG; j++) begin
            out_gregs[j*REG_W +: REG_W] = res_gregs_q[j];
            greg_flat[j*REG_W +: REG_W] = greg_q[j];
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_key_q <= '0;
            upd_key_q <= '0;
            hdr_q     <= '0;
            res_hit_q <= 1'b0;
            res_act_q <= '0;
            res_nst_q <= '0;
            for (int i = 0; i < NUM_FREG; i++) res_fregs_q[i] <= '0;
            for (int j = 0; j < NUM_GREG; j++) begin
                res_gregs_q[j] <= '0;
                greg_q[j]      <= '0;
            end
        end else begin
            if (in_valid && in_ready) begin
                pkt_key_q <= in_key;
                upd_key_q <= in_upd_key;
                hdr_q     <= in_hdr;
            end
            if (state_q == S_MATCH) begin
                res_hit_q <= tc_hit;
                res_act_q <= tc_hit ? tc_act : ACT_W'(DROP_ACT);
                res_nst_q <= tc_hit ? tc_nst : ctx_rd_state;
                for (int i = 0; i < NUM_FREG; i++) res_fregs_q[i] <= new_opnd[i];
                for (int j = 0; j < NUM_GREG; j++) res_gregs_q[j] <= new_opnd[NUM_FREG + j];
            end
            if (state_q == S_WRITE)
                for (int j = 0; j < NUM_GREG; j++) greg_q[j] <= res_gregs_q[j];
        end
    end

    // R2: one packet in flight, result two cycles after acceptance
    assert_single_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    assert_result_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid);
    // R5: a miss reports drop and keeps the current state
    assert_miss_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MATCH && !tc_hit) |=>
            (out_action == ACT_W'(DROP_ACT) && out_next_state == $past(ctx_rd_state)));
    // R9: global registers change only when a result is committed
    assert_globals_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WRITE) |=> $stable(greg_flat));
endmodule

// File: tb/test_flow_state_stage.sv
`timescale 1ns/1ps
module test_flow_state_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_key = '0, in_upd_key = '0;
    logic [7:0]  in_hdr = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [11:0] cfg_val = '0, cfg_mask = '0;
    logic [3:0]  cfg_action = '0, cfg_next_state = '0;
    logic [43:0] cfg_ins = '0;
    logic        out_valid, out_hit;
    logic [3:0]  out_action, out_next_state;
    logic [31:0] out_fregs, out_gregs;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flow_state_stage i_flow_state_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .in_upd_key(in_upd_key), .in_hdr(in_hdr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_val(cfg_val),
        .cfg_mask(cfg_mask), .cfg_action(cfg_action), .cfg_next_state(cfg_next_state),
        .cfg_ins(cfg_ins), .out_valid(out_valid), .out_hit(out_hit),
        .out_action(out_action), .out_next_state(out_next_state),
        .out_fregs(out_fregs), .out_gregs(out_gregs)
    );

    typedef struct {
        logic        hit;
        logic [3:0]  act;
        logic [3:0]  nst;
        logic [31:0] fregs;
        logic [31:0] gregs;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // reference model state
    logic        m_en   [8];
    logic [11:0] m_val  [8];
    logic [11:0] m_mask [8];
    logic [3:0]  m_act  [8];
    logic [3:0]  m_nst  [8];
    logic [43:0] m_ins  [8];
    logic        m_vld  [16];
    logic [15:0] m_key  [16];
    logic [3:0]  m_st   [16];
    logic [15:0] m_f0   [16];
    logic [15:0] m_f1   [16];
    logic [15:0] m_g    [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input int op, input int dst, input int src, input int imm);
        return {op[1:0], dst[1:0], src[1:0], imm[15:0]};
    endfunction

    task automatic cfg(input int idx, input bit en, input logic [11:0] val,
                       input logic [11:0] mask, input int act, input int nst,
                       input logic [21:0] s0, input logic [21:0] s1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_en = en; cfg_val = val; cfg_mask = mask;
        cfg_action = act[3:0]; cfg_next_state = nst[3:0]; cfg_ins = {s1, s0};
        m_en[idx] = en; m_val[idx] = val; m_mask[idx] = mask;
        m_act[idx] = act[3:0]; m_nst[idx] = nst[3:0]; m_ins[idx] = {s1, s0};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] key, input logic [15:0] upd,
                        input logic [7:0] hdr, input string tag);
        exp_t e;
        logic [3:0]  st;
        logic [15:0] o [4];
        logic [15:0] n [4];
        logic [21:0] w;
        int win;
        int slot;
        slot = int'(key[3:0]);
        if (m_vld[slot] && m_key[slot] == key) begin
            st = m_st[slot]; o[0] = m_f0[slot]; o[1] = m_f1[slot];
        end else begin
            st = 4'd0; o[0] = '0; o[1] = '0;
        end
        o[2] = m_g[0]; o[3] = m_g[1];
        n = o;
        win = -1;
        for (int i = 7; i >= 0; i--)
            if (m_en[i] && ((({st, hdr}) ^ m_val[i]) & m_mask[i]) == 12'd0) win = i;
        e.tag = tag;
        e.hit = (win >= 0);
        if (win < 0) begin
            e.act = 4'd0; e.nst = st;
        end else begin
            e.act = m_act[win]; e.nst = m_nst[win];
            for (int s = 0; s < 2; s++) begin
                w = m_ins[win][s*22 +: 22];
                case (w[21:20])
                    2'd1: n[w[19:18]] = o[w[17:16]] + w[15:0];
                    2'd2: n[w[19:18]] = o[w[17:16]] - w[15:0];
                    2'd3: n[w[19:18]] = w[15:0];
                    default: ;
                endcase
            end
            m_vld[upd[3:0]] = 1'b1; m_key[upd[3:0]] = upd; m_st[upd[3:0]] = e.nst;
            m_f0[upd[3:0]] = n[0]; m_f1[upd[3:0]] = n[1];
            m_g[0] = n[2]; m_g[1] = n[3];
        end
        e.fregs = {n[1], n[0]};
        e.gregs = {n[3], n[2]};
        exp_q.push_back(e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_key = key; in_upd_key = upd; in_hdr = hdr;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready && !out_valid, "R2", "busy after accept", {30'd0, in_ready, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid && !in_ready, "R2", "result cycle", {30'd0, in_ready, out_valid}, 32'd1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(out_hit == e.hit, e.tag, "hit", {31'd0, out_hit}, {31'd0, e.hit});
                chk(out_action == e.act, e.tag, "action", {28'd0, out_action}, {28'd0, e.act});
                chk(out_next_state == e.nst, e.tag, "next_state",
                    {28'd0, out_next_state}, {28'd0, e.nst});
                chk(out_fregs == e.fregs, e.tag, "flow regs", out_fregs, e.fregs);
                chk(out_gregs == e.gregs, e.tag, "global regs", out_gregs, e.gregs);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_en[i] = 1'b0; m_val[i] = '0; m_mask[i] = '0;
            m_act[i] = '0; m_nst[i] = '0; m_ins[i] = '0;
        end
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0; m_key[i] = '0; m_st[i] = '0; m_f0[i] = '0; m_f1[i] = '0;
        end
        m_g[0] = '0; m_g[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(in_ready == 1'b1, "R1", "in_ready", {31'd0, in_ready}, 32'd1);
        chk(out_valid == 1'b0, "R1", "out_valid", {31'd0, out_valid}, 32'd0);

        // R1/R5: no entries enabled -> miss, nothing written
        send(16'h0101, 16'h0101, 8'h10, "R5");
        send(16'h0101, 16'h0101, 8'h10, "R5");

        // program entries (R12)
        cfg(0, 1'b1, {4'd0, 8'h10}, 12'hFFF, 1, 1, mk(1, 0, 0, 1),      mk(1, 2, 2, 1));
        cfg(1, 1'b1, {4'd1, 8'h00}, 12'hF00, 2, 2, mk(1, 0, 0, 1),      mk(1, 1, 1, 100));
        cfg(2, 1'b1, {4'd2, 8'h80}, 12'hF80, 3, 0, mk(3, 0, 0, 16'h55), mk(3, 0, 0, 16'h77));
        cfg(3, 1'b1, {4'd2, 8'h00}, 12'hF00, 4, 2, mk(2, 3, 3, 5),      mk(1, 1, 0, 1));
        cfg(4, 1'b1, 12'h000,       12'h000, 5, 3, 22'd0,               22'd0);

        send(16'h0101, 16'h0101, 8'h10, "R6");   // R3 default -> entry 0
        send(16'h0101, 16'h0101, 8'h20, "R11");  // sees state 1
        send(16'h0101, 16'h0101, 8'h80, "R4");   // entries 2 and 3 hit, 2 wins; R8 collision
        send(16'h0101, 16'h0101, 8'h01, "R4");   // only catch-all hits
        send(16'h0101, 16'h0101, 8'h10, "R11");  // state 3, catch-all
        send(16'h0202, 16'h0202, 8'h10, "R9");   // second flow bumps shared global
        send(16'h0505, 16'h0606, 8'h10, "R10");  // stored under update key
        send(16'h0606, 16'h0606, 8'h20, "R10");  // sees state 1
        send(16'h0505, 16'h0505, 8'h10, "R3");   // lookup key still new
        send(16'h1202, 16'h1202, 8'h10, "R13");  // takes slot 2
        send(16'h0202, 16'h0202, 8'h10, "R13");  // restarts from default
        send(16'h0707, 16'h0707, 8'h10, "R7");
        send(16'h0707, 16'h0707, 8'h20, "R7");
        send(16'h0707, 16'h0707, 8'h00, "R8");   // sub wraps global 1; slot 1 reads old f0
        cfg(0, 1'b0, {4'd0, 8'h10}, 12'hFFF, 1, 1, mk(1, 0, 0, 1), mk(1, 2, 2, 1));
        send(16'h0909, 16'h0909, 8'h10, "R12");  // disabled entry 0 -> catch-all

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule